// File: doc/BRIEF.md
# Strobe Write Capture Filter

This block sits at the front of a parallel, flash-like storage device and turns the raw chip-select, write-strobe and output-enable pins into clean write events inside a fast clock domain. All three strobes, a low-supply flag, and the address and data buses are sampled by the system clock through a fixed-depth synchroniser. The address and data buses go through a delay line of the same depth, so every sample of the buses stays aligned with the matching sample of the strobes. A write window is open on every sample in which chip select and write strobe are both low.

The address is taken from the first sample of a window, which is the later of the two falling edges. The data is taken from the last sample of the window, just before the earlier of the two rising edges. A window yields a write only if it lasts at least `MIN_LOW` samples and no sample inside it saw output enable low or the low-supply flag set. A qualified window produces a one-clock pulse on `wr_valid_o`, together with the captured address and data, a fixed number of cycles after the window closes. The command decoder behind the block consumes this pulse.

Top module: `strobe_write_capture`

## Requirements
- R1: After reset `wr_valid_o` is 0, and it stays 0 until a qualified window has closed.
- R2: `wr_addr_o` carries the value that `addr_i` had on the first sample in which both `ce_n_i` and `we_n_i` were low, whichever of the two fell last.
- R3: `wr_data_o` carries the value that `data_i` had on the last sample in which both strobes were low, whichever of the two rose first; later bus changes are not taken.
- R4: Each qualified window produces exactly one `wr_valid_o` pulse, one clock wide, issued only after the window has closed. Two windows back to back give two pulses, in order.
- R5: A window of fewer than `MIN_LOW` low samples (default 3) produces no write, and a window of exactly `MIN_LOW` samples produces one.
- R6: If `oe_n_i` is low on any sample inside a window, that window produces no write.
- R7: If `lowv_i` is high on any sample inside a window, that window produces no write.
- R8: Pulsing `we_n_i` low while `ce_n_i` stays high produces no write, and pulsing `ce_n_i` low while `we_n_i` stays high produces no write.
- R9: With `SYNC_STAGES` = 2, `wr_valid_o` rises on the third rising clock edge after the input edge that closes the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ce_n_i | input | 1 | Raw chip select, active low, asynchronous |
| we_n_i | input | 1 | Raw write strobe, active low, asynchronous |
| oe_n_i | input | 1 | Raw output enable, active low; low inhibits writes |
| lowv_i | input | 1 | Low-supply indication; high inhibits writes |
| addr_i | input | AW | Raw address bus |
| data_i | input | DW | Raw data bus |
| wr_valid_o | output | 1 | One-cycle write event pulse |
| wr_addr_o | output | AW | Address captured at window open |
| wr_data_o | output | DW | Data captured at window close |

## Verification
Windows are driven with chip select falling first and with the write strobe falling first, and are closed with either strobe rising first. During each window the address is changed after the first low sample and the data is held at a decoy value until the last low sample, so capturing on the wrong edge shows up as a wrong value. Window lengths of one, two and three samples straddle the filter threshold, and output-enable or low-supply pulses placed mid-window separate an inhibit that is checked on every sample from one checked only at the window edges. Single-strobe pulses, back-to-back windows and a measured close-to-pulse latency complete the patterns.

// File: rtl/swc_pkg.sv
package swc_pkg;
  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_t;
endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= {W{RST_VAL}};
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= {W{RST_VAL}};
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/swc_window.sv
module swc_window
  import swc_pkg::*;
#(
  parameter int MIN_LOW = 3,
  localparam int CNT_W  = $clog2(MIN_LOW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_s,
  input  logic inh_s,
  output logic open_o,
  output logic hold_o,
  output logic fire_o
);
  win_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             abort_q, abort_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    abort_d = abort_q;
    open_o  = 1'b0;
    hold_o  = win_s;
    fire_o  = 1'b0;
    case (st_q)
      WIN_IDLE: begin
        if (win_s) begin
          st_d    = WIN_OPEN;
          open_o  = 1'b1;
          cnt_d   = CNT_W'(1);
          abort_d = inh_s;
        end
      end
      WIN_OPEN: begin
        if (win_s) begin
          if (cnt_q != CNT_W'(MIN_LOW)) cnt_d = cnt_q + CNT_W'(1);
          abort_d = abort_q | inh_s;
        end else begin
          st_d   = WIN_IDLE;
          fire_o = (cnt_q == CNT_W'(MIN_LOW)) && !abort_q;
        end
      end
      default: st_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WIN_IDLE;
      cnt_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      abort_q <= abort_d;
    end
  end
endmodule

// File: rtl/swc_capture.sv
module swc_capture #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          open_i,
  input  logic          hold_i,
  input  logic          fire_i,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          vld_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          vld_q;

  always_comb begin
    addr_d = open_i ? addr_s : addr_q;
    data_d = hold_i ? data_s : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      vld_q  <= fire_i;
    end
  end

  assign vld_o  = vld_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/strobe_write_capture.sv
module strobe_write_capture #(
  parameter int AW          = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_LOW     = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic          lowv_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int BW = AW + DW;

  logic          rst_meta, rst_sync_n;
  logic [2:0]    strb_s;
  logic          ce_s, we_s, oe_s, lowv_s, win_s;
  logic [BW-1:0] bus_s;
  logic          open_w, hold_w, fire_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  swc_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d({ce_n_i, we_n_i, oe_n_i}), .q(strb_s)
  );

  swc_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lowv_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(lowv_i), .q(lowv_s)
  );

  swc_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_bus_align (
    .clk(clk), .rst_n(rst_sync_n), .d({addr_i, data_i}), .q(bus_s)
  );

  assign ce_s  = strb_s[2];
  assign we_s  = strb_s[1];
  assign oe_s  = strb_s[0];
  assign win_s = !ce_s && !we_s;

  swc_window #(.MIN_LOW(MIN_LOW)) u_window (
    .clk(clk), .rst_n(rst_sync_n),
    .win_s(win_s), .inh_s(!oe_s || lowv_s),
    .open_o(open_w), .hold_o(hold_w), .fire_o(fire_w)
  );

  swc_capture #(.AW(AW), .DW(DW)) u_capture (
    .clk(clk), .rst_n(rst_sync_n),
    .open_i(open_w), .hold_i(hold_w), .fire_i(fire_w),
    .addr_s(bus_s[BW-1:DW]), .data_s(bus_s[DW-1:0]),
    .vld_o(wr_valid_o), .addr_o(wr_addr_o), .data_o(wr_data_o)
  );
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int MIN_LOW = 3,
  localparam int RW     = $clog2(MIN_LOW + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic win_s,
  input logic oe_s,
  input logic lowv_s,
  input logic wr_valid_o
);
  logic          win_p, oe_hit, lv_hit;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_p  <= 1'b0;
      oe_hit <= 1'b0;
      lv_hit <= 1'b0;
      run_q  <= '0;
    end else begin
      win_p <= win_s;
      if (win_s && !win_p) begin
        run_q  <= RW'(1);
        oe_hit <= !oe_s;
        lv_hit <= lowv_s;
      end else if (win_s) begin
        if (run_q != RW'(MIN_LOW)) run_q <= run_q + RW'(1);
        oe_hit <= oe_hit | !oe_s;
        lv_hit <= lv_hit | lowv_s;
      end
    end
  end

  // R4
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |=> !wr_valid_o);

  // R4
  valid_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> !win_p);

  // R5
  min_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> run_q == RW'(MIN_LOW));

  // R6
  oe_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> !oe_hit);

  // R7
  lowv_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> !lv_hit);
endmodule

bind strobe_write_capture swc_checker #(.MIN_LOW(MIN_LOW)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_s(win_s), .oe_s(oe_s),
  .lowv_s(lowv_s), .wr_valid_o(wr_valid_o)
);

// File: tb/strobe_write_capture_tb.sv
`timescale 1ns/1ps
module strobe_write_capture_tb;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ce_n, we_n, oe_n, lowv;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  logic          wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int pulses = 0;
  int last_pulse_cyc = 0;
  int close_cyc = 0;
  logic [AW+DW-1:0] exp_q [$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  strobe_write_capture #(.AW(AW), .DW(DW), .SYNC_STAGES(2), .MIN_LOW(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .lowv_i(lowv), .addr_i(addr), .data_i(data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every write pulse (R2 R3 R4)
  always @(negedge clk) begin
    if (rst_n && wr_valid) begin
      pulses++;
      last_pulse_cyc = cyc;
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected write", int'(wr_addr), 0);
      end else begin
        logic [AW+DW-1:0] e;
        e = exp_q.pop_front();
        check(wr_addr == e[AW+DW-1:DW], "R2 address", int'(wr_addr), int'(e[AW+DW-1:DW]));
        check(wr_data == e[DW-1:0], "R3 data", int'(wr_data), int'(e[DW-1:0]));
      end
    end
  end

  task automatic win(input bit ce_first, input bit we_rises_first, input int n_low,
                     input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expect_w,
                     input bit oe_pulse, input bit lv_pulse, input int idle);
    @(negedge clk);
    addr = ~a; data = ~d;
    if (ce_first) ce_n = 1'b0; else we_n = 1'b0;
    @(negedge clk);
    addr = a;
    data = (n_low == 1) ? d : (d ^ 8'h5A);
    if (ce_first) we_n = 1'b0; else ce_n = 1'b0;
    for (int i = 1; i < n_low; i++) begin
      @(negedge clk);
      addr = a ^ 16'h00FF;
      data = (i == n_low - 1) ? d : (d ^ 8'h5A);
      if (i == 1) begin
        if (oe_pulse) oe_n = 1'b0;
        if (lv_pulse) lowv = 1'b1;
      end
    end
    if (expect_w) exp_q.push_back({a, d});
    @(negedge clk);
    close_cyc = cyc;
    data = ~d; oe_n = 1'b1; lowv = 1'b0;
    if (we_rises_first) we_n = 1'b1; else ce_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (idle) @(negedge clk);
  endtask

  task automatic expect_none(input int p0, input string req);
    check(pulses == p0, req, pulses - p0, 0);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int p0;
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lowv = 1'b0;
    addr = '0; data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1
    check(wr_valid == 1'b0 && pulses == 0, "R1 reset idle", int'(wr_valid), 0);

    // R2 R3: chip select first, write strobe rises first
    win(1'b1, 1'b1, 4, 16'h1234, 8'hA5, 1'b1, 1'b0, 1'b0, 5);
    // R9: latency from closing edge
    check(last_pulse_cyc == close_cyc + 3, "R9 latency", last_pulse_cyc - close_cyc, 3);
    // R2 R3: write strobe first, chip select rises first
    win(1'b0, 1'b0, 5, 16'hBEEF, 8'h3C, 1'b1, 1'b0, 1'b0, 5);
    win(1'b1, 1'b0, 4, 16'h0F0F, 8'h81, 1'b1, 1'b0, 1'b0, 5);
    win(1'b0, 1'b1, 4, 16'hFFFF, 8'h00, 1'b1, 1'b0, 1'b0, 5);

    // R5: threshold boundaries
    p0 = pulses;
    win(1'b1, 1'b1, 1, 16'h1111, 8'h11, 1'b0, 1'b0, 1'b0, 5);
    expect_none(p0, "R5 one-sample window rejected");
    p0 = pulses;
    win(1'b0, 1'b1, 2, 16'h2222, 8'h22, 1'b0, 1'b0, 1'b0, 5);
    expect_none(p0, "R5 two-sample window rejected");
    p0 = pulses;
    win(1'b1, 1'b1, 3, 16'h3333, 8'h33, 1'b1, 1'b0, 1'b0, 5);
    check(pulses == p0 + 1, "R5 three-sample window accepted", pulses - p0, 1);

    // R6: output enable low inside window
    p0 = pulses;
    win(1'b1, 1'b1, 5, 16'h4444, 8'h44, 1'b0, 1'b1, 1'b0, 5);
    expect_none(p0, "R6 output enable inhibit");

    // R7: low-supply inside window
    p0 = pulses;
    win(1'b0, 1'b0, 5, 16'h5555, 8'h55, 1'b0, 1'b0, 1'b1, 5);
    expect_none(p0, "R7 low supply inhibit");

    // R6: output enable low only outside the window has no effect
    @(negedge clk); oe_n = 1'b0;
    repeat (3) @(negedge clk); oe_n = 1'b1;
    repeat (3) @(negedge clk);
    p0 = pulses;
    win(1'b1, 1'b1, 4, 16'h6666, 8'h66, 1'b1, 1'b0, 1'b0, 5);
    check(pulses == p0 + 1, "R6 inhibit confined to window", pulses - p0, 1);

    // R8: single-strobe pulses
    p0 = pulses;
    @(negedge clk); addr = 16'h7777; data = 8'h77; we_n = 1'b0;
    repeat (5) @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk); ce_n = 1'b0;
    repeat (5) @(negedge clk); ce_n = 1'b1;
    repeat (6) @(negedge clk);
    expect_none(p0, "R8 single strobe ignored");

    // R4: back-to-back windows
    p0 = pulses;
    win(1'b1, 1'b1, 3, 16'h8001, 8'hC1, 1'b1, 1'b0, 1'b0, 0);
    win(1'b0, 1'b0, 3, 16'h8002, 8'hC2, 1'b1, 1'b0, 1'b0, 6);
    check(pulses == p0 + 2, "R4 two windows two pulses", pulses - p0, 2);

    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule